// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic stage of a small accumulator-style core. Each accepted operation combines the working register value with a second operand (a file register or a literal) and returns an 8-bit result, the destination select for that result, and the five status flags carry (C), digit carry (DC), zero (Z), overflow (OV) and negative (N). The caller supplies the current flags, so operations that consume carry or digit carry see the architectural state. Operations that leave a flag alone copy that flag from the input to the output.

All arithmetic shares one adder with a carry out of the middle of the word, which gives a digit-carry flag for binary-coded decimal work. A decimal-adjust operation uses that flag and the carry to fix up the working register after a BCD addition. An unsigned multiply writes a separate 16-bit product pair and touches neither the result port nor the flags. All outputs are registered, so results appear one clock after the operation is presented.

Top module: `alu8_flags`

## Requirements
- R1: An operation presented with `op_valid` high is taken at a rising clock edge and its outputs appear after that edge; `res_valid` and `prod_valid` are high for exactly that one cycle and low when no operation was taken, while the data outputs hold. Synchronous reset clears every output to zero.
- R2: Flags are packed as bit 0 C, bit 1 DC, bit 2 Z, bit 3 OV, bit 4 N. Code 0 (add) returns W+F and code 1 (add with carry) returns W+F+C; C is the carry out of bit 7, DC the carry from bit 3 into bit 4, OV signals a signed result out of range, Z a zero result and N result bit 7 (0x9F+0x52 gives 0xF1 with N=1, OV=0, Z=0, C=0, DC=1).
- R3: Code 2 returns F-W and code 3 returns F-W-(1-C), computed as F + ~W + carry-in, so C=1 means no borrow and C=0 means a borrow; DC, OV, Z and N follow the rules of R2.
- R4: Code 4 returns F+1, code 5 returns F-1 (F plus all ones) and code 6 returns the two's complement of F (~F plus one), each setting all five flags from that addition.
- R5: Code 7 (complement F), 8 (W AND F), 9 (W OR F), 10 (W XOR F) and 15 (swap the nibbles of F) update only Z and N; C, DC and OV are copied from the input flags.
- R6: Code 11 rotates F left through carry (C enters bit 0, bit 7 goes to C) and code 12 rotates F right through carry (C enters bit 7, bit 0 goes to C); Z and N are updated, DC and OV copied.
- R7: Code 13 rotates F left and code 14 rotates F right without carry; C, DC and OV are copied and only Z and N are updated.
- R8: Code 16 decimal-adjusts W: 0x06 is added when the low digit exceeds 9 or DC is set, then 0x60 when the high digit of that sum exceeds 9, C is set or the first step carried; C is set exactly when the second step is applied and all other flags are copied.
- R9: Code 17 multiplies W and F unsigned into `prod_hi`/`prod_lo` with `prod_valid` high and `res_valid` low; flags are copied from the input, and the product pair changes on no other operation.
- R10: `res_dest` returns the destination select given with the operation (0 working register, 1 file register).
- R11: Codes 18 to 31 produce no result and no product (both valid outputs low, result and product unchanged) and copy the input flags to the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| dest_sel | input | 1 | Destination select carried with the operation |
| wreg_in | input | 8 | Working register operand |
| opnd_in | input | 8 | File or literal operand |
| flags_in | input | 5 | Current status flags {N,OV,Z,DC,C} |
| res_valid | output | 1 | Result valid for one cycle |
| res_data | output | 8 | Result byte |
| res_dest | output | 1 | Destination select of the result |
| flags_out | output | 5 | Updated status flags {N,OV,Z,DC,C} |
| prod_valid | output | 1 | Product valid for one cycle |
| prod_hi | output | 8 | Product high byte |
| prod_lo | output | 8 | Product low byte |

## Verification
The hardest corners are the ones where flags interact: a digit carry with no byte carry, signed overflow on negating 0x80 or decrementing 0x80, and decimal adjust reached through each of its three triggers (large digit, incoming DC or C, first-step carry). Because the flags are an input rather than internal state, the stimulus reaches these states directly by presenting chosen incoming flag values alongside the operands, and it also checks that flags an operation must leave alone come out equal to unusual incoming values. The product pair is checked to hold its value across later non-multiply operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBB = 5'd3,
    OP_INC  = 5'd4,
    OP_DEC  = 5'd5,
    OP_NEG  = 5'd6,
    OP_COM  = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_RLC  = 5'd11,
    OP_RRC  = 5'd12,
    OP_RL   = 5'd13,
    OP_RR   = 5'd14,
    OP_SWAP = 5'd15,
    OP_DAW  = 5'd16,
    OP_MUL  = 5'd17
  } alu_op_e;

  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_OV = 3;
  localparam int FLG_N  = 4;
  localparam int FLG_W  = 5;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         dcout,
  output logic         ovf
);
  localparam int NIB = W / 2;

  logic [W:0]   full;
  logic [NIB:0] low;

  assign full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign low   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
  assign sum   = full[W-1:0];
  assign cout  = full[W];
  assign dcout = low[NIB];
  assign ovf   = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     wreg,
  input  logic [W-1:0]     opnd,
  input  logic [FLG_W-1:0] flags_in,
  output logic             hit,
  output logic [W-1:0]     res,
  output logic [FLG_W-1:0] flags
);
  localparam int NIB = W / 2;
  localparam logic [NIB-1:0] DIG_MAX = NIB'(9);
  localparam logic [W:0] LO_FIX = (W+1)'(6);
  localparam logic [W:0] HI_FIX = (W+1)'(6) << NIB;

  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_cin, add_cout, add_dc, add_ov;
  logic         use_adder;

  always_comb begin
    add_a     = wreg;
    add_b     = opnd;
    add_cin   = 1'b0;
    use_adder = 1'b1;
    case (op)
      OP_ADD:  ;
      OP_ADDC: add_cin = flags_in[FLG_C];
      OP_SUB:  begin add_a = opnd; add_b = ~wreg; add_cin = 1'b1; end
      OP_SUBB: begin add_a = opnd; add_b = ~wreg; add_cin = flags_in[FLG_C]; end
      OP_INC:  begin add_a = opnd; add_b = '0; add_cin = 1'b1; end
      OP_DEC:  begin add_a = opnd; add_b = '1; end
      OP_NEG:  begin add_a = ~opnd; add_b = '0; add_cin = 1'b1; end
      default: use_adder = 1'b0;
    endcase
  end

  alu8_adder #(.W(W)) i_adder (
    .a(add_a), .b(add_b), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .dcout(add_dc), .ovf(add_ov)
  );

  logic         lo_need, hi_need;
  logic [W:0]   daw_s1, daw_s2;

  always_comb begin
    lo_need = (wreg[NIB-1:0] > DIG_MAX) || flags_in[FLG_DC];
    daw_s1  = {1'b0, wreg} + (lo_need ? LO_FIX : '0);
    hi_need = flags_in[FLG_C] || daw_s1[W] || (daw_s1[W-1:NIB] > DIG_MAX);
    daw_s2  = {1'b0, daw_s1[W-1:0]} + (hi_need ? HI_FIX : '0);
  end

  always_comb begin
    hit   = 1'b0;
    res   = add_sum;
    flags = flags_in;
    if (use_adder) begin
      hit          = 1'b1;
      flags[FLG_C]  = add_cout;
      flags[FLG_DC] = add_dc;
      flags[FLG_Z]  = (add_sum == '0);
      flags[FLG_OV] = add_ov;
      flags[FLG_N]  = add_sum[W-1];
    end else if (op == OP_DAW) begin
      hit          = 1'b1;
      res          = daw_s2[W-1:0];
      flags[FLG_C] = hi_need;
    end
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     wreg,
  input  logic [W-1:0]     opnd,
  input  logic [FLG_W-1:0] flags_in,
  output logic             hit,
  output logic [W-1:0]     res,
  output logic [FLG_W-1:0] flags
);
  localparam int NIB = W / 2;

  logic c_in;
  logic c_new;
  logic c_upd;

  assign c_in = flags_in[FLG_C];

  always_comb begin
    hit   = 1'b1;
    c_upd = 1'b0;
    c_new = c_in;
    res   = opnd;
    case (op)
      OP_COM:  res = ~opnd;
      OP_AND:  res = wreg & opnd;
      OP_OR:   res = wreg | opnd;
      OP_XOR:  res = wreg ^ opnd;
      OP_RLC:  begin res = {opnd[W-2:0], c_in}; c_new = opnd[W-1]; c_upd = 1'b1; end
      OP_RRC:  begin res = {c_in, opnd[W-1:1]}; c_new = opnd[0]; c_upd = 1'b1; end
      OP_RL:   res = {opnd[W-2:0], opnd[W-1]};
      OP_RR:   res = {opnd[0], opnd[W-1:1]};
      OP_SWAP: res = {opnd[NIB-1:0], opnd[W-1:NIB]};
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    flags        = flags_in;
    flags[FLG_Z] = (res == '0);
    flags[FLG_N] = res[W-1];
    if (c_upd) flags[FLG_C] = c_new;
  end
endmodule

// File: rtl/alu8_mult.sv
module alu8_mult #(
  parameter int W         = 8,
  parameter bit USE_ARRAY = 1'b1
) (
  input  logic [W-1:0]   wreg,
  input  logic [W-1:0]   opnd,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  generate
    if (USE_ARRAY) begin : g_array
      logic [PW-1:0] acc [W+1];
      assign acc[0] = '0;
      for (genvar i = 0; i < W; i++) begin : g_row
        logic [PW-1:0] part;
        assign part     = opnd[i] ? ({{W{1'b0}}, wreg} << i) : '0;
        assign acc[i+1] = acc[i] + part;
      end
      assign prod = acc[W];
    end else begin : g_native
      assign prod = {{W{1'b0}}, wreg} * {{W{1'b0}}, opnd};
    end
  endgenerate
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W         = 8,
  parameter bit USE_ARRAY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [4:0]       op_code,
  input  logic             dest_sel,
  input  logic [W-1:0]     wreg_in,
  input  logic [W-1:0]     opnd_in,
  input  logic [FLG_W-1:0] flags_in,
  output logic             res_valid,
  output logic [W-1:0]     res_data,
  output logic             res_dest,
  output logic [FLG_W-1:0] flags_out,
  output logic             prod_valid,
  output logic [W-1:0]     prod_hi,
  output logic [W-1:0]     prod_lo
);
  localparam int PW = 2 * W;

  alu_op_e op;
  assign op = alu_op_e'(op_code);

  logic             ar_hit, bo_hit, mul_hit;
  logic [W-1:0]     ar_res, bo_res;
  logic [FLG_W-1:0] ar_flags, bo_flags;
  logic [PW-1:0]    product;

  alu8_arith #(.W(W)) i_arith (
    .op(op), .wreg(wreg_in), .opnd(opnd_in), .flags_in(flags_in),
    .hit(ar_hit), .res(ar_res), .flags(ar_flags)
  );

  alu8_bitops #(.W(W)) i_bitops (
    .op(op), .wreg(wreg_in), .opnd(opnd_in), .flags_in(flags_in),
    .hit(bo_hit), .res(bo_res), .flags(bo_flags)
  );

  alu8_mult #(.W(W), .USE_ARRAY(USE_ARRAY)) i_mult (
    .wreg(wreg_in), .opnd(opnd_in), .prod(product)
  );

  assign mul_hit = (op == OP_MUL);

  logic [W-1:0]     sel_res;
  logic [FLG_W-1:0] sel_flags;

  always_comb begin
    if (ar_hit) begin
      sel_res   = ar_res;
      sel_flags = ar_flags;
    end else if (bo_hit) begin
      sel_res   = bo_res;
      sel_flags = bo_flags;
    end else begin
      sel_res   = res_data;
      sel_flags = flags_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_data   <= '0;
      res_dest   <= 1'b0;
      flags_out  <= '0;
      prod_valid <= 1'b0;
      prod_hi    <= '0;
      prod_lo    <= '0;
    end else begin
      res_valid  <= 1'b0;
      prod_valid <= 1'b0;
      if (op_valid) begin
        res_dest  <= dest_sel;
        flags_out <= sel_flags;
        if (ar_hit || bo_hit) begin
          res_valid <= 1'b1;
          res_data  <= sel_res;
        end
        if (mul_hit) begin
          prod_valid <= 1'b1;
          prod_hi    <= product[PW-1:W];
          prod_lo    <= product[W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [4:0]       op_code,
  input logic             dest_sel,
  input logic [FLG_W-1:0] flags_in,
  input logic             res_valid,
  input logic [W-1:0]     res_data,
  input logic             res_dest,
  input logic [FLG_W-1:0] flags_out,
  input logic             prod_valid,
  input logic [W-1:0]     prod_hi,
  input logic [W-1:0]     prod_lo
);
  logic is_mul, is_zn_only, is_rot_nc, zn_updated;
  assign is_mul     = (op_code == 5'(OP_MUL));
  assign is_zn_only = (op_code == 5'(OP_COM)) || (op_code == 5'(OP_AND)) ||
                      (op_code == 5'(OP_OR))  || (op_code == 5'(OP_XOR)) ||
                      (op_code == 5'(OP_SWAP));
  assign is_rot_nc  = (op_code == 5'(OP_RL)) || (op_code == 5'(OP_RR));
  assign zn_updated = (op_code <= 5'(OP_SWAP));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && !prod_valid));

  p_one_valid_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_valid, prod_valid}));

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && zn_updated) |=> (flags_out[FLG_Z] == (res_data == '0)));

  p_neg_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && zn_updated) |=> (flags_out[FLG_N] == res_data[W-1]));

  p_logic_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_zn_only) |=>
      (flags_out[FLG_C] == $past(flags_in[FLG_C]) &&
       flags_out[FLG_DC] == $past(flags_in[FLG_DC]) &&
       flags_out[FLG_OV] == $past(flags_in[FLG_OV])));

  p_rot_keep_c_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_rot_nc) |=> (flags_out[FLG_C] == $past(flags_in[FLG_C])));

  p_mul_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_mul) |=> (prod_valid && !res_valid && flags_out == $past(flags_in)));

  p_prod_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && is_mul) |=> $stable({prod_hi, prod_lo}));

  p_dest_r10: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (res_dest == $past(dest_sel)));

  p_unused_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > 5'(OP_MUL)) |=>
      (!res_valid && !prod_valid && flags_out == $past(flags_in)));
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .dest_sel(dest_sel), .flags_in(flags_in), .res_valid(res_valid),
  .res_data(res_data), .res_dest(res_dest), .flags_out(flags_out),
  .prod_valid(prod_valid), .prod_hi(prod_hi), .prod_lo(prod_lo)
);

// File: tb/test_alu8_flags.sv
module test_alu8_flags;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic       dest_sel = 1'b0;
  logic [7:0] wreg_in = '0;
  logic [7:0] opnd_in = '0;
  logic [4:0] flags_in = '0;
  logic       res_valid, res_dest, prod_valid;
  logic [7:0] res_data, prod_hi, prod_lo;
  logic [4:0] flags_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flags i_alu8_flags (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .dest_sel(dest_sel), .wreg_in(wreg_in), .opnd_in(opnd_in),
    .flags_in(flags_in), .res_valid(res_valid), .res_data(res_data),
    .res_dest(res_dest), .flags_out(flags_out), .prod_valid(prod_valid),
    .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  // {op, w, f, flags_in, expected result, expected flags {N,OV,Z,DC,C}}
  localparam logic [38:0] VEC [NVEC] = '{
    {5'd0,  8'h9F, 8'h52, 5'h00, 8'hF1, 5'h12},
    {5'd0,  8'h80, 8'h80, 5'h00, 8'h00, 5'h0D},
    {5'd0,  8'h7F, 8'h01, 5'h00, 8'h80, 5'h1A},
    {5'd1,  8'h0F, 8'h00, 5'h01, 8'h10, 5'h02},
    {5'd2,  8'h03, 8'h05, 5'h00, 8'h02, 5'h03},
    {5'd2,  8'h05, 8'h03, 5'h00, 8'hFE, 5'h10},
    {5'd2,  8'h01, 8'h80, 5'h00, 8'h7F, 5'h09},
    {5'd3,  8'h05, 8'h05, 5'h00, 8'hFF, 5'h10},
    {5'd3,  8'h05, 8'h05, 5'h01, 8'h00, 5'h07},
    {5'd4,  8'h00, 8'hFF, 5'h00, 8'h00, 5'h07},
    {5'd5,  8'h00, 8'h00, 5'h00, 8'hFF, 5'h10},
    {5'd5,  8'h00, 8'h80, 5'h00, 8'h7F, 5'h09},
    {5'd6,  8'h00, 8'h80, 5'h00, 8'h80, 5'h1A},
    {5'd6,  8'h00, 8'h01, 5'h00, 8'hFF, 5'h10},
    {5'd7,  8'h00, 8'hFF, 5'h0B, 8'h00, 5'h0F},
    {5'd8,  8'hF0, 8'h3C, 5'h00, 8'h30, 5'h00},
    {5'd9,  8'h80, 8'h01, 5'h07, 8'h81, 5'h13},
    {5'd10, 8'hAA, 8'hAA, 5'h10, 8'h00, 5'h04},
    {5'd11, 8'h00, 8'h81, 5'h00, 8'h02, 5'h01},
    {5'd12, 8'h00, 8'h01, 5'h01, 8'h80, 5'h11},
    {5'd13, 8'h00, 8'h81, 5'h00, 8'h03, 5'h00},
    {5'd14, 8'h00, 8'h01, 5'h01, 8'h80, 5'h11},
    {5'd15, 8'h00, 8'hA5, 5'h00, 8'h5A, 5'h00},
    {5'd16, 8'h9F, 8'h00, 5'h00, 8'h05, 5'h01},
    {5'd16, 8'h12, 8'h00, 5'h02, 8'h18, 5'h02},
    {5'd16, 8'h00, 8'h00, 5'h01, 8'h60, 5'h01}
  };

  function automatic string tag_of(input logic [4:0] op);
    if (op <= 5'd1)                   return "R2";
    if (op <= 5'd3)                   return "R3";
    if (op <= 5'd6)                   return "R4";
    if (op == 5'd11 || op == 5'd12)   return "R6";
    if (op == 5'd13 || op == 5'd14)   return "R7";
    if (op == 5'd16)                  return "R8";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive on a falling edge, taken at the next rising edge, sampled at the next falling edge
  task automatic issue(input logic [4:0] op, input logic [7:0] w, input logic [7:0] f,
                       input logic [4:0] fin, input logic d);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; wreg_in = w; opnd_in = f; flags_in = fin; dest_sel = d;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!res_valid && !prod_valid, "R1", "valids after reset", {14'd0, res_valid, prod_valid}, 16'd0);
    check(res_data == 8'h00 && flags_out == 5'h00, "R1", "result/flags after reset",
          {res_data, 3'd0, flags_out}, 16'd0);
    check({prod_hi, prod_lo} == 16'h0000, "R1", "product after reset", {prod_hi, prod_lo}, 16'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [4:0] v_op, v_fin, v_fl;
      logic [7:0] v_w, v_f, v_res;
      {v_op, v_w, v_f, v_fin, v_res, v_fl} = VEC[i];
      issue(v_op, v_w, v_f, v_fin, 1'b0);
      check(res_valid == 1'b1, tag_of(v_op), "res_valid", {15'd0, res_valid}, 16'd1);
      check(res_data == v_res, tag_of(v_op), "result", {8'd0, res_data}, {8'd0, v_res});
      check(flags_out == v_fl, tag_of(v_op), "flags", {11'd0, flags_out}, {11'd0, v_fl});
    end

    // R10 destination select follows the operation
    issue(5'd0, 8'h01, 8'h02, 5'h00, 1'b1);
    check(res_dest == 1'b1, "R10", "dest file", {15'd0, res_dest}, 16'd1);
    issue(5'd8, 8'hFF, 8'h0F, 5'h00, 1'b0);
    check(res_dest == 1'b0, "R10", "dest working", {15'd0, res_dest}, 16'd0);

    // R1 idle cycle: no valid, data held
    @(negedge clk);
    check(!res_valid && !prod_valid, "R1", "idle valids", {14'd0, res_valid, prod_valid}, 16'd0);
    check(res_data == 8'h0F, "R1", "idle hold", {8'd0, res_data}, 16'h000F);

    // R9 multiply
    issue(5'd17, 8'hFF, 8'hFF, 5'h1F, 1'b0);
    check({prod_hi, prod_lo} == 16'hFE01, "R9", "product FFxFF", {prod_hi, prod_lo}, 16'hFE01);
    check(prod_valid && !res_valid, "R9", "mul valids", {14'd0, res_valid, prod_valid}, 16'd1);
    check(flags_out == 5'h1F, "R9", "mul flags", {11'd0, flags_out}, 16'h001F);
    check(res_data == 8'h0F, "R9", "mul leaves result", {8'd0, res_data}, 16'h000F);
    issue(5'd0, 8'h10, 8'h20, 5'h00, 1'b0);
    check({prod_hi, prod_lo} == 16'hFE01, "R9", "product held", {prod_hi, prod_lo}, 16'hFE01);
    issue(5'd17, 8'h0C, 8'h0A, 5'h00, 1'b0);
    check({prod_hi, prod_lo} == 16'h0078, "R9", "product 0Cx0A", {prod_hi, prod_lo}, 16'h0078);

    // R11 unused code
    issue(5'd0, 8'h11, 8'h22, 5'h00, 1'b0);
    issue(5'd20, 8'h55, 8'h66, 5'h15, 1'b0);
    check(!res_valid && !prod_valid, "R11", "unused valids", {14'd0, res_valid, prod_valid}, 16'd0);
    check(flags_out == 5'h15, "R11", "unused flags", {11'd0, flags_out}, 16'h0015);
    check(res_data == 8'h33, "R11", "unused result held", {8'd0, res_data}, 16'h0033);
    check({prod_hi, prod_lo} == 16'h0078, "R11", "unused product held", {prod_hi, prod_lo}, 16'h0078);

    // R1 reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(res_data == 8'h00 && flags_out == 5'h00 && {prod_hi, prod_lo} == 16'h0000, "R1",
          "reset clears", {res_data, 3'd0, flags_out}, 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule